// File: doc/BRIEF.md
# Carry-Save Running Accumulator

This block adds a stream of signed 16-bit words into a 40-bit running total. It does not keep the total as one binary number. It keeps a pair of vectors, a partial-sum vector and a saved-carry vector, and the true total is their sum. Each accepted word goes into a single row of 3:2 compressors together with the two stored vectors. The accumulate path is therefore one full-adder deep at every width, and no carry crosses a bit position on that path.

A binary total is formed only when one is asked for. A two-level carry-lookahead adder adds the two vectors together. It uses 4-bit groups and a group-level lookahead above them. The adder output is registered, so the result and its valid flag appear on the cycle after the request. A synchronous clear empties the total. Typical uses are DSP sums and bignum partial products, where many terms go in and the total is read only now and then.

Top module: `csacc_top`

## Requirements
- R1: After reset, res_valid_o is 0, res_o is 0, and the first read returns 0.
- R2: Each cycle with in_valid_i high adds in_data_i, read as two's complement and sign-extended to 40 bits, to the running total. A read returns that total.
- R3: A cycle with in_valid_i low and clr_i low leaves the total unchanged.
- R4: res_valid_o is 1 exactly in the cycle after a cycle with rd_req_i high. In every other cycle it is 0. res_o keeps its value between reads.
- R5: A read requested in a cycle that also adds or clears returns the total as it stood before that cycle.
- R6: clr_i high empties the total. If in_valid_i is also high in that cycle, the total afterwards equals the sign-extended input word alone.
- R7: The total wraps modulo 2^40. For example, 0 minus 1 reads as 0xFFFFFFFFFF, and adding 1 to that reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the total |
| in_valid_i | input | 1 | Qualifies in_data_i |
| in_data_i | input | 16 | Signed input word |
| rd_req_i | input | 1 | Request to resolve and register the total |
| res_o | output | 40 | Resolved binary total |
| res_valid_o | output | 1 | High for one cycle when res_o has been updated |

## Verification
The assertions assume that all control inputs are at known 0/1 levels at every clock edge after reset is released. They also assume that rd_req_i, clr_i and in_valid_i are held low while reset is asserted. The bench drives every input on the falling edge and holds it for the whole cycle. It starts from an all-zero drive during reset and never leaves an input undriven. This keeps the past-value checks on the redundant state and on the resolved result meaningful from the first sampled edge.

// File: rtl/csacc_pkg.sv
package csacc_pkg;
  localparam int unsigned IN_W_DEF  = 16;
  localparam int unsigned ACC_W_DEF = 40;
  localparam int unsigned GRP_W     = 4;
endpackage

// File: rtl/csa_row.sv
module csa_row #(
  parameter int unsigned W = 40
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s_o[i] = x_i[i] ^ y_i[i] ^ z_i[i];
    assign c_o[i] = (x_i[i] & y_i[i]) | (x_i[i] & z_i[i]) | (y_i[i] & z_i[i]);
  end
endmodule

// File: rtl/cla_grp4.sv
module cla_grp4 (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       cin_i,
  output logic [3:0] s_o,
  output logic       gg_o,
  output logic       gp_o
);
  logic [3:0] g, p;
  logic [3:0] c;

  assign g = a_i & b_i;
  assign p = a_i ^ b_i;

  // flat lookahead, no ripple inside the group
  assign c[0] = cin_i;
  assign c[1] = g[0] | (p[0] & cin_i);
  assign c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cin_i);
  assign c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & cin_i);

  assign s_o  = p ^ c;
  assign gg_o = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0]);
  assign gp_o = &p;
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int unsigned W = 40
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  localparam int unsigned GW = csacc_pkg::GRP_W;
  localparam int unsigned NG = W / GW;

  logic [NG-1:0] gg, gp, gcin;

  // second level: each group carry-in from all lower group G/P in parallel
  always_comb begin
    for (int j = 0; j < NG; j++) begin
      logic acc;
      acc = 1'b0;
      for (int k = 0; k < j; k++) begin
        logic t;
        t = gg[k];
        for (int m = k + 1; m < j; m++) t = t & gp[m];
        acc = acc | t;
      end
      gcin[j] = acc;
    end
  end

  for (genvar j = 0; j < NG; j++) begin : g_grp
    cla_grp4 u_grp (
      .a_i  (a_i[j*GW +: GW]),
      .b_i  (b_i[j*GW +: GW]),
      .cin_i(gcin[j]),
      .s_o  (s_o[j*GW +: GW]),
      .gg_o (gg[j]),
      .gp_o (gp[j])
    );
  end
endmodule

// File: rtl/csacc_top.sv
module csacc_top #(
  parameter int unsigned IN_W  = csacc_pkg::IN_W_DEF,
  parameter int unsigned ACC_W = csacc_pkg::ACC_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             in_valid_i,
  input  logic [IN_W-1:0]  in_data_i,
  input  logic             rd_req_i,
  output logic [ACC_W-1:0] res_o,
  output logic             res_valid_o
);
  localparam int unsigned EXT_W = ACC_W - IN_W;

  logic [ACC_W-1:0] sum_q, car_q;
  logic [ACC_W-1:0] op, base_s, base_c, row_s, row_c, resolved;
  logic             upd;

  assign op     = in_valid_i ? {{EXT_W{in_data_i[IN_W-1]}}, in_data_i} : '0;
  assign base_s = clr_i ? '0 : sum_q;
  assign base_c = clr_i ? '0 : car_q;
  assign upd    = clr_i | in_valid_i;

  csa_row #(.W(ACC_W)) u_row (
    .x_i(op),
    .y_i(base_s),
    .z_i(base_c),
    .s_o(row_s),
    .c_o(row_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      car_q <= '0;
    end else if (upd) begin
      sum_q <= row_s;
      car_q <= {row_c[ACC_W-2:0], 1'b0};  // carry weight x2
    end
  end

  cla_adder #(.W(ACC_W)) u_cla (
    .a_i(sum_q),
    .b_i(car_q),
    .s_o(resolved)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o       <= '0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= rd_req_i;
      if (rd_req_i) res_o <= resolved;
    end
  end
endmodule

// File: rtl/csacc_chk.sv
module csacc_chk #(
  parameter int unsigned ACC_W = 40
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             in_valid_i,
  input logic             rd_req_i,
  input logic [ACC_W-1:0] sum_q,
  input logic [ACC_W-1:0] car_q,
  input logic [ACC_W-1:0] res_o,
  input logic             res_valid_o
);
  assert_valid_after_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> res_valid_o);

  assert_no_spurious_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !res_valid_o);

  assert_result_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> $stable(res_o));

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !in_valid_i) |=> ($stable(sum_q) && $stable(car_q)));

  assert_clear_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !in_valid_i) |=> (sum_q == '0 && car_q == '0));

  assert_read_prior_state_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> (res_o == ACC_W'($past(sum_q) + $past(car_q))));
endmodule

bind csacc_top csacc_chk #(.ACC_W(ACC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .in_valid_i (in_valid_i),
  .rd_req_i   (rd_req_i),
  .sum_q      (sum_q),
  .car_q      (car_q),
  .res_o      (res_o),
  .res_valid_o(res_valid_o)
);

// File: tb/sim_csacc_top.sv
`timescale 1ns/1ps
module sim_csacc_top;
  localparam int unsigned IN_W  = 16;
  localparam int unsigned ACC_W = 40;
  localparam logic [15:0] TBL [12] = '{
    16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h5555, 16'hAAAA,
    16'h0F0F, 16'hF0F0, 16'h7FFF, 16'h7FFF, 16'h8001, 16'h1234
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             clr_i = 1'b0;
  logic             in_valid_i = 1'b0;
  logic [IN_W-1:0]  in_data_i = '0;
  logic             rd_req_i = 1'b0;
  logic [ACC_W-1:0] res_o;
  logic             res_valid_o;

  int checks = 0;
  int errors = 0;
  logic [ACC_W-1:0] model = '0;

  always #2.5 clk = ~clk;

  csacc_top #(.IN_W(IN_W), .ACC_W(ACC_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr_i), .in_valid_i(in_valid_i),
    .in_data_i(in_data_i), .rd_req_i(rd_req_i), .res_o(res_o), .res_valid_o(res_valid_o)
  );

  function automatic logic [ACC_W-1:0] sx(input logic [IN_W-1:0] d);
    return {{(ACC_W-IN_W){d[IN_W-1]}}, d};
  endfunction

  task automatic check(input string req, input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive after falling edge, sample at the next falling edge
  task automatic cyc(input logic c, input logic v, input logic [IN_W-1:0] d, input logic r);
    clr_i = c; in_valid_i = v; in_data_i = d; rd_req_i = r;
    @(negedge clk);
    clr_i = 1'b0; in_valid_i = 1'b0; in_data_i = '0; rd_req_i = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [ACC_W-1:0] exp);
    cyc(1'b0, 1'b0, '0, 1'b1);
    check(req, ACC_W'(res_valid_o), ACC_W'(1));
    check(req, res_o, exp);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", ACC_W'(res_valid_o), '0);
    check("R1", res_o, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    read_chk("R1", '0);

    // R2 table walk
    for (int i = 0; i < 12; i++) begin
      cyc(1'b0, 1'b1, TBL[i], 1'b0);
      model = model + sx(TBL[i]);
      read_chk("R2", model);
    end

    // R3 idle cycles do not disturb the total
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 16'hBEEF, 1'b0);
    read_chk("R3", model);

    // R4 valid only after a read, result held
    cyc(1'b0, 1'b1, 16'h0100, 1'b0);
    check("R4", ACC_W'(res_valid_o), '0);
    check("R4", res_o, model);
    model = model + sx(16'h0100);

    // R5 read with concurrent add sees prior total
    cyc(1'b0, 1'b1, 16'h0042, 1'b1);
    check("R5", res_o, model);
    model = model + sx(16'h0042);
    read_chk("R5", model);

    // R6 clear alone, then clear with input
    cyc(1'b1, 1'b0, '0, 1'b0);
    model = '0;
    read_chk("R6", '0);
    cyc(1'b0, 1'b1, 16'h1111, 1'b0);
    cyc(1'b1, 1'b1, 16'hFFFE, 1'b1);
    check("R6", res_o, sx(16'h1111));
    model = sx(16'hFFFE);
    read_chk("R6", model);

    // R7 wrap modulo 2^40
    cyc(1'b1, 1'b1, 16'hFFFF, 1'b0);
    read_chk("R7", 40'hFF_FFFF_FFFF);
    cyc(1'b0, 1'b1, 16'h0001, 1'b0);
    read_chk("R7", '0);
    model = '0;

    // R2/R5/R6 random mix
    for (int i = 0; i < 3000; i++) begin
      logic c, v, r;
      logic [IN_W-1:0] d;
      c = ($urandom % 40) == 0;
      v = ($urandom % 4) != 0;
      r = ($urandom % 5) == 0;
      d = IN_W'($urandom);
      cyc(c, v, d, r);
      if (r) check("R5", res_o, model);
      if (c) model = '0;
      if (v) model = model + sx(d);
    end
    read_chk("R2", model);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule